// File: doc/BRIEF.md
# FEC Symbol Error Rate Monitor

This block sits beside a two-lane Reed-Solomon FEC decoder and watches what it reports about each codeword. Every cycle it takes a 3-bit symbol error increment from each lane and adds both into a running window total. It also takes a strobe that marks each decoded codeword, and single-cycle pulses for corrected and uncorrected codewords. The window is counted in codewords, not in time. When the total within one window grows past a fixed limit, the block raises a high symbol error rate flag. The flag stays up until a full later window closes at or under the limit.

Three configuration inputs set the mode: FEC enable, correction enable and indication enable. They are captured once, on the first clock after reset is released. The flag can only be raised in bypass indication mode, which means FEC is enabled and indication is disabled. Next to the flag, four saturating statistics counters accumulate the corrected codewords, the uncorrected codewords and the symbol errors of each lane. When FEC is disabled, every output stays at zero.

A small state machine holds the mode and the flag:

- `ST_CFG_SAMPLE` is the first cycle after reset. It captures the configuration and moves to `ST_FEC_OFF` if FEC is disabled. Otherwise it moves to `ST_STATS_ONLY` if indication is enabled, and to `ST_RATE_OK` if it is not.
- `ST_FEC_OFF` and `ST_STATS_ONLY` are held until the next reset.
- `ST_RATE_OK` moves to `ST_RATE_HIGH` when the window total, including the current cycle, goes past the limit.
- `ST_RATE_HIGH` returns to `ST_RATE_OK` on a window-closing codeword whose window total is at or under the limit.

Top module: `fec_ser_monitor`

## Requirements
- R1: The three configuration inputs are captured on the first rising edge after reset is released. All other inputs present in that cycle are ignored. Later changes to the configuration inputs have no effect until the next reset.
- R2: With FEC enable captured as 0, `hi_ser` and all four statistics counters stay at 0 whatever the inputs do.
- R3: `hi_ser` can be 1 only when FEC enable was captured as 1 and indication enable was captured as 0. With indication enable captured as 1, the flag stays 0 but the statistics counters still count.
- R4: A window spans CW_PER_WIN (default 8192) codeword strobes. The cycle carrying the last strobe of the window closes it and clears both the codeword count and the error total. The errors of that closing cycle count toward the closing window only and are not carried into the next one. The error total saturates at 2^TOT_W-1 instead of wrapping.
- R5: `hi_ser` rises on the clock edge at which the window total, including that cycle's increments, first exceeds ERR_LIMIT (default 417). A total of 418 raises the flag and a total of exactly 417 does not.
- R6: Once raised, `hi_ser` stays 1 until the closing cycle of a window whose total is ERR_LIMIT or less, and falls on that edge.
- R7: The lane 0 and lane 1 increments are both added to the window total on every cycle, whether or not the codeword strobe is present.
- R8: The uncorrected counter adds one per uncorrected pulse. The corrected counter adds one per corrected pulse only when correction enable was captured as 1, and stays 0 otherwise.
- R9: Each lane counter adds its lane's increment every active cycle. All four statistics counters saturate at 2^STAT_W-1 and clear on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fec_en | input | 1 | FEC enable, captured after reset |
| cfg_corr_en | input | 1 | Correction enable, captured after reset |
| cfg_ind_en | input | 1 | Indication enable, captured after reset |
| cw_strobe | input | 1 | One pulse per decoded codeword |
| lane0_sym_inc | input | SYM_INC_W | Lane 0 symbol error increment |
| lane1_sym_inc | input | SYM_INC_W | Lane 1 symbol error increment |
| corr_cw_pulse | input | 1 | Corrected codeword event |
| uncorr_cw_pulse | input | 1 | Uncorrected codeword event |
| hi_ser | output | 1 | High symbol error rate flag |
| corr_cw_count | output | STAT_W | Saturating corrected codeword count |
| uncorr_cw_count | output | STAT_W | Saturating uncorrected codeword count |
| lane0_err_count | output | STAT_W | Saturating lane 0 symbol error count |
| lane1_err_count | output | STAT_W | Saturating lane 1 symbol error count |

## Verification
Each result is registered once, so it appears one rising edge after the inputs that caused it:
- The flag rise and fall and every counter step show one edge after the cycle whose increments or pulses caused them.
- The configuration takes effect from the first edge after reset release.

The bench changes inputs on the falling edge and lets exactly one rising edge pass. It then steps a reference model and compares the outputs on the following falling edge. Directed checks placed at the 417/418 boundary and at window-closing strobes therefore look at the cycle in which the flag is due to change.

// File: rtl/fec_ser_pkg.sv
package fec_ser_pkg;

    typedef enum logic [2:0] {
        ST_CFG_SAMPLE,
        ST_FEC_OFF,
        ST_STATS_ONLY,
        ST_RATE_OK,
        ST_RATE_HIGH
    } mon_state_t;

    localparam int NUM_STATS  = 4;
    localparam int STAT_CORR  = 0;
    localparam int STAT_UNC   = 1;
    localparam int STAT_LANE0 = 2;
    localparam int STAT_LANE1 = 3;

endpackage

// File: rtl/fec_sat_counter.sv
module fec_sat_counter #(
    parameter int CNT_W = 32,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W:0] sum_ext;

    always_comb begin
        sum_ext = {1'b0, count} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (en) begin
            count <= sum_ext[CNT_W] ? '1 : sum_ext[CNT_W-1:0];
        end
    end

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '1) |=> (count == '1));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (count >= $past(count)));

endmodule

// File: rtl/fec_ser_window.sv
module fec_ser_window #(
    parameter int CW_PER_WIN = 8192,
    parameter int ERR_LIMIT  = 417,
    parameter int INC_W      = 3,
    parameter int TOT_W      = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cw_strobe,
    input  logic [INC_W-1:0] lane0_inc,
    input  logic [INC_W-1:0] lane1_inc,
    output logic             win_end,
    output logic             over_now
);

    localparam int              CW_W    = $clog2(CW_PER_WIN);
    localparam logic [CW_W-1:0] LAST_CW = CW_W'(CW_PER_WIN - 1);
    localparam logic [TOT_W-1:0] LIM_V  = TOT_W'(ERR_LIMIT);

    logic [CW_W-1:0]  cw_cnt;
    logic [TOT_W-1:0] err_total;
    logic [INC_W:0]   lane_sum;
    logic [TOT_W:0]   tot_ext;
    logic [TOT_W-1:0] total_now;

    always_comb begin
        lane_sum  = {1'b0, lane0_inc} + {1'b0, lane1_inc};
        tot_ext   = {1'b0, err_total} + {{(TOT_W - INC_W){1'b0}}, lane_sum};
        total_now = tot_ext[TOT_W] ? '1 : tot_ext[TOT_W-1:0];
        over_now  = run && (total_now > LIM_V);
        win_end   = run && cw_strobe && (cw_cnt == LAST_CW);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cw_cnt    <= '0;
            err_total <= '0;
        end else if (win_end) begin
            cw_cnt    <= '0;
            err_total <= '0;
        end else begin
            err_total <= total_now;
            if (cw_strobe) begin
                cw_cnt <= cw_cnt + 1'b1;
            end
        end
    end

    // R4
    win_clear_chk: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (cw_cnt == '0 && err_total == '0));

    // R4
    total_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !win_end) |=> (!run || err_total >= $past(err_total)));

endmodule

// File: rtl/fec_ser_monitor.sv
module fec_ser_monitor
    import fec_ser_pkg::*;
#(
    parameter int STAT_W     = 32,
    parameter int CW_PER_WIN = 8192,
    parameter int ERR_LIMIT  = 417,
    parameter int SYM_INC_W  = 3,
    parameter int TOT_W      = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_fec_en,
    input  logic                 cfg_corr_en,
    input  logic                 cfg_ind_en,
    input  logic                 cw_strobe,
    input  logic [SYM_INC_W-1:0] lane0_sym_inc,
    input  logic [SYM_INC_W-1:0] lane1_sym_inc,
    input  logic                 corr_cw_pulse,
    input  logic                 uncorr_cw_pulse,
    output logic                 hi_ser,
    output logic [STAT_W-1:0]    corr_cw_count,
    output logic [STAT_W-1:0]    uncorr_cw_count,
    output logic [STAT_W-1:0]    lane0_err_count,
    output logic [STAT_W-1:0]    lane1_err_count
);

    mon_state_t state, state_nxt;
    logic fec_q, corr_q, ind_q;
    logic run, win_end, over_now;

    logic [SYM_INC_W-1:0] inc_vec [NUM_STATS];
    logic [NUM_STATS-1:0] en_vec;
    logic [STAT_W-1:0]    cnt_vec [NUM_STATS];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_CFG_SAMPLE;
            fec_q  <= 1'b0;
            corr_q <= 1'b0;
            ind_q  <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == ST_CFG_SAMPLE) begin
                fec_q  <= cfg_fec_en;
                corr_q <= cfg_corr_en;
                ind_q  <= cfg_ind_en;
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_CFG_SAMPLE: begin
                if (!cfg_fec_en)     state_nxt = ST_FEC_OFF;
                else if (cfg_ind_en) state_nxt = ST_STATS_ONLY;
                else                 state_nxt = ST_RATE_OK;
            end
            ST_FEC_OFF:    state_nxt = ST_FEC_OFF;
            ST_STATS_ONLY: state_nxt = ST_STATS_ONLY;
            ST_RATE_OK:    if (over_now) state_nxt = ST_RATE_HIGH;
            ST_RATE_HIGH:  if (win_end && !over_now) state_nxt = ST_RATE_OK;
            default:       state_nxt = ST_CFG_SAMPLE;
        endcase
    end

    always_comb begin
        hi_ser = (state == ST_RATE_HIGH);
        run    = (state == ST_STATS_ONLY) || (state == ST_RATE_OK) ||
                 (state == ST_RATE_HIGH);
        inc_vec[STAT_CORR]  = {{(SYM_INC_W - 1){1'b0}}, corr_cw_pulse};
        inc_vec[STAT_UNC]   = {{(SYM_INC_W - 1){1'b0}}, uncorr_cw_pulse};
        inc_vec[STAT_LANE0] = lane0_sym_inc;
        inc_vec[STAT_LANE1] = lane1_sym_inc;
        en_vec              = {NUM_STATS{run}};
        en_vec[STAT_CORR]   = run && corr_q;
        corr_cw_count       = cnt_vec[STAT_CORR];
        uncorr_cw_count     = cnt_vec[STAT_UNC];
        lane0_err_count     = cnt_vec[STAT_LANE0];
        lane1_err_count     = cnt_vec[STAT_LANE1];
    end

    fec_ser_window #(
        .CW_PER_WIN (CW_PER_WIN),
        .ERR_LIMIT  (ERR_LIMIT),
        .INC_W      (SYM_INC_W),
        .TOT_W      (TOT_W)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .cw_strobe (cw_strobe),
        .lane0_inc (lane0_sym_inc),
        .lane1_inc (lane1_sym_inc),
        .win_end   (win_end),
        .over_now  (over_now)
    );

    for (genvar g = 0; g < NUM_STATS; g++) begin : g_stat
        fec_sat_counter #(
            .CNT_W (STAT_W),
            .INC_W (SYM_INC_W)
        ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .en    (en_vec[g]),
            .inc   (inc_vec[g]),
            .count (cnt_vec[g])
        );
    end

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CFG_SAMPLE) |=> $stable({fec_q, corr_q, ind_q}));

    // R2
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FEC_OFF) |-> (!hi_ser && corr_cw_count == '0 &&
            uncorr_cw_count == '0 && lane0_err_count == '0 && lane1_err_count == '0));

    // R3
    flag_mode_chk: assert property (@(posedge clk) disable iff (rst)
        hi_ser |-> (fec_q && !ind_q));

    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RATE_OK && over_now) |=> hi_ser);

    // R6
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hi_ser) |-> $past(win_end));

endmodule

// File: tb/fec_ser_monitor_tb.sv
module fec_ser_monitor_tb_top;

    localparam int  SW   = 10;
    localparam int  WIN  = 8192;
    localparam int  LIM  = 417;
    localparam longint SMAX = (64'd1 << SW) - 1;
    localparam int  TMAX = 16383;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic cfg_fec = 1'b0, cfg_corr = 1'b0, cfg_ind = 1'b0;
    logic strb = 1'b0, cp = 1'b0, up = 1'b0;
    logic [2:0] l0 = '0, l1 = '0;
    logic hi_ser;
    logic [SW-1:0] c_corr, c_unc, c_l0, c_l1;

    int checks = 0;
    int errors = 0;

    bit m_first, m_fec, m_corr, m_ind, m_flag;
    int m_cw, m_tot;
    longint m_c [4];

    fec_ser_monitor #(.STAT_W(SW)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_fec_en      (cfg_fec),
        .cfg_corr_en     (cfg_corr),
        .cfg_ind_en      (cfg_ind),
        .cw_strobe       (strb),
        .lane0_sym_inc   (l0),
        .lane1_sym_inc   (l1),
        .corr_cw_pulse   (cp),
        .uncorr_cw_pulse (up),
        .hi_ser          (hi_ser),
        .corr_cw_count   (c_corr),
        .uncorr_cw_count (c_unc),
        .lane0_err_count (c_l0),
        .lane1_err_count (c_l1)
    );

    function automatic longint sat_add(input longint a, input longint b, input longint mx);
        return (a + b > mx) ? mx : a + b;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_edge();
        int tot;
        bit endw;
        if (rst) begin
            m_first = 1; m_cw = 0; m_tot = 0; m_flag = 0;
            for (int k = 0; k < 4; k++) m_c[k] = 0;
        end else if (m_first) begin
            m_first = 0; m_fec = cfg_fec; m_corr = cfg_corr; m_ind = cfg_ind;
        end else if (m_fec) begin
            tot  = m_tot + int'(l0) + int'(l1);
            if (tot > TMAX) tot = TMAX;
            endw = strb && (m_cw == WIN - 1);
            if (!m_ind) begin
                if (!m_flag && tot > LIM) m_flag = 1;
                else if (m_flag && endw && tot <= LIM) m_flag = 0;
            end
            if (endw) begin
                m_cw = 0; m_tot = 0;
            end else begin
                m_tot = tot;
                if (strb) m_cw++;
            end
            if (m_corr) m_c[0] = sat_add(m_c[0], longint'(cp), SMAX);
            m_c[1] = sat_add(m_c[1], longint'(up), SMAX);
            m_c[2] = sat_add(m_c[2], longint'(l0), SMAX);
            m_c[3] = sat_add(m_c[3], longint'(l1), SMAX);
        end
    endtask

    task automatic compare(input string tag);
        chk(hi_ser == m_flag, tag, longint'(hi_ser), longint'(m_flag));
        chk(longint'(c_corr) == m_c[0], tag, longint'(c_corr), m_c[0]);
        chk(longint'(c_unc)  == m_c[1], tag, longint'(c_unc),  m_c[1]);
        chk(longint'(c_l0)   == m_c[2], tag, longint'(c_l0),   m_c[2]);
        chk(longint'(c_l1)   == m_c[3], tag, longint'(c_l1),   m_c[3]);
    endtask

    task automatic step(input logic [2:0] a, input logic [2:0] b, input logic s,
                        input logic c, input logic u, input string tag);
        l0 = a; l1 = b; strb = s; cp = c; up = u;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input logic f, input logic c, input logic i);
        rst = 1'b1;
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, "R9");
        rst = 1'b0; cfg_fec = f; cfg_corr = c; cfg_ind = i;
        // R1: inputs of the capture cycle are ignored
        step(3'd7, 3'd7, 1, 1, 1, "R1");
        chk(c_l0 == 0 && c_unc == 0, "R1", longint'(c_l0), 0);
    endtask

    task automatic rnd_step(input int rate, input string tag);
        logic [2:0] a, b;
        a = ($urandom % 1000 < rate) ? 3'($urandom) : 3'd0;
        b = ($urandom % 1000 < rate) ? 3'($urandom) : 3'd0;
        step(a, b, 1'($urandom), ($urandom % 10) == 0, ($urandom % 10) == 0, tag);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset(1, 1, 0);
        chk(hi_ser == 0, "R9", longint'(hi_ser), 0);

        // R5: exactly 417 errors in a window, no flag
        for (int i = 0; i < WIN; i++) step(i < 139 ? 3'd3 : 3'd0, 3'd0, 1, 0, 0, "R5");
        chk(hi_ser == 0, "R5", longint'(hi_ser), 0);

        // R5 / R7: 418th error arrives on lane 1
        for (int i = 0; i < WIN; i++) begin
            step(i < 139 ? 3'd3 : 3'd0, i == 200 ? 3'd1 : 3'd0, 1, 0, 0, "R5");
            if (i == 199) chk(hi_ser == 0, "R5", longint'(hi_ser), 0);
            if (i == 200) chk(hi_ser == 1, "R7", longint'(hi_ser), 1);
        end

        // R6: clean window keeps flag until its closing strobe
        for (int i = 0; i < WIN; i++) begin
            step(0, 0, 1, 0, 0, "R6");
            if (i == WIN - 2) chk(hi_ser == 1, "R6", longint'(hi_ser), 1);
        end
        chk(hi_ser == 0, "R6", longint'(hi_ser), 0);

        // R4: errors in the closing cycle count toward that window
        for (int i = 0; i < WIN; i++) begin
            step(i < 101 ? 3'd4 : (i == WIN - 1 ? 3'd7 : 3'd0),
                 i == WIN - 1 ? 3'd7 : 3'd0, 1, 0, 0, "R4");
            if (i == WIN - 2) chk(hi_ser == 0, "R4", longint'(hi_ser), 0);
        end
        chk(hi_ser == 1, "R4", longint'(hi_ser), 1);

        // R4: closing-cycle errors are not carried; 404 in this window
        for (int i = 0; i < WIN; i++) begin
            step(i < 101 ? 3'd4 : 3'd0, 3'd0, 1, 0, 0, "R4");
            if (i == WIN - 2) chk(hi_ser == 1, "R6", longint'(hi_ser), 1);
        end
        chk(hi_ser == 0, "R4", longint'(hi_ser), 0);
        chk(longint'(c_l0) == SMAX, "R9", longint'(c_l0), SMAX);

        // R7: random strobes and errors on strobe-free cycles
        for (int i = 0; i < 40000; i++) rnd_step(4, "R7");

        // R1: configuration changes mid-run have no effect
        cfg_fec = 0; cfg_ind = 1; cfg_corr = 0;
        for (int i = 0; i < 5000; i++) rnd_step(10, "R1");

        // R3: indication enabled, flag held low, counters run
        do_reset(1, 1, 1);
        for (int i = 0; i < 2000; i++) step(3'd7, 3'd7, 1, 1, 1, "R3");
        chk(hi_ser == 0, "R3", longint'(hi_ser), 0);
        chk(longint'(c_l1) == SMAX, "R9", longint'(c_l1), SMAX);

        // R2: FEC disabled, everything idle
        do_reset(0, 1, 0);
        for (int i = 0; i < 300; i++) step(3'd7, 3'd7, 1, 1, 1, "R2");
        chk(hi_ser == 0 && c_corr == 0 && c_unc == 0 && c_l0 == 0 && c_l1 == 0,
            "R2", longint'(c_l0) + longint'(c_unc), 0);

        // R8: correction disabled
        do_reset(1, 0, 0);
        for (int i = 0; i < 200; i++) step(0, 0, 1, 1, 1, "R8");
        chk(c_corr == 0, "R8", longint'(c_corr), 0);
        chk(longint'(c_unc) == 200, "R8", longint'(c_unc), 200);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule